// File: doc/BRIEF.md
# Address-Programmable Clocked Delay Line

This block delays a single-bit signal by a whole number of clock cycles. The delay is picked by a 6-bit address. It is a fixed inherent latency plus the address times a step size. Both the latency and the step are elaboration-time parameters counted in cycles. The block is built from three parts:

- a shift register that records the input once per clock;
- a multiplexer that picks one stage of that register, using the live address;
- a registered output stage.

The address is not captured. A change to it retargets the tap on the very next clock edge, so the user keeps it steady for as long as a delay setting is in use. Avoiding glitches during retargeting is left to a separate guard block.

An active-high disable clamps the output low. It does not stop the shift register, so data entered while the block is disabled still comes out later at its normal time. A synchronous active-high reset clears every stage and the output.

Top module: `prog_delay_line`

## Requirements
- R1: With the address held at A and the disable low, the value on `din` at clock edge m appears on `dout` right after edge m + INHERENT + A*STEP.
- R2: Address 0 gives the shortest delay, INHERENT cycles (default 2).
- R3: Address 63 gives the longest delay, INHERENT + 63*STEP cycles (default 65).
- R4: Each increase of the address by one lengthens the delay by exactly STEP cycles, so the delay rises strictly with the code over all 64 codes.
- R5: The address is used live. After edge n, `dout` shows the input value from edge n − (INHERENT + A*STEP), where A is the address present at edge n, even if A differs from the address of the previous cycle.
- R6: Whenever `dis` is 1 at a clock edge, `dout` is 0 after that edge, whatever the data and the address are.
- R7: The disable does not disturb the stored history. Values entered on `din` while `dis` is 1 still come out on `dout` at their normal delay once `dis` returns to 0.
- R8: When `rst` is 1 at a clock edge, `dout` is 0 after that edge and every stored stage is cleared. Ones entered before the reset never reach `dout` afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Data input sampled every cycle |
| addr | input | 6 | Delay code 0..63, used unlatched |
| dis | input | 1 | Active-high disable; clamps `dout` low |
| dout | output | 1 | Registered delayed data |

## Verification
The hardest case to reach from the ports is a retarget onto a stage whose contents differ from the current output. A new address only shows when the old tap and the new tap hold different bits. The stimulus therefore first fills the whole chain with random data. It then changes the address on most cycles, including jumps between 0 and 63, so that every retarget lands on a distinct history bit. Isolated single pulses, sent one address at a time, measure each delay explicitly and so show the step between neighbouring codes.

// File: rtl/pdl_pkg.sv
package pdl_pkg;
  // Number of stored stages needed for a given latency, step and address width
  function automatic int chain_depth(input int inherent, input int step, input int aw);
    return inherent + ((1 << aw) - 1) * step;
  endfunction
endpackage

// File: rtl/pdl_shift_chain.sv
module pdl_shift_chain #(
  parameter int DEPTH = 65
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  output logic [DEPTH-1:0] taps
);
  // taps[k] holds the input sampled k+1 edges ago
  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) taps[0] <= 1'b0;
        else     taps[0] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) taps[g] <= 1'b0;
        else     taps[g] <= taps[g-1];
      end
    end
  end

  // Reset leaves no stored bit behind
  assert_chain_clear_R8: assert property (@(posedge clk) rst |=> (taps == '0))
    else $error("chain not cleared by reset");
endmodule

// File: rtl/pdl_tap_select.sv
module pdl_tap_select #(
  parameter int INHERENT = 2,
  parameter int STEP     = 1,
  parameter int ADDR_W   = 6,
  parameter int DEPTH    = 65
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DEPTH-1:0]  taps,
  input  logic [ADDR_W-1:0] addr,
  output logic              tap_bit
);
  localparam int IDX_W = $clog2(DEPTH + 1);

  logic [IDX_W-1:0] idx;

  always_comb begin
    idx     = IDX_W'(INHERENT - 1) + IDX_W'(addr) * IDX_W'(STEP);
    tap_bit = taps[idx];
  end

  // Largest code must still land inside the chain
  assert_tap_in_range_R3: assert property (@(posedge clk) disable iff (rst)
    idx < IDX_W'(DEPTH))
    else $error("tap index beyond chain");

  // A larger code always selects a later stage
  assert_tap_monotonic_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(addr) < addr) |-> ($past(idx) < idx))
    else $error("tap order not monotonic");
endmodule

// File: rtl/pdl_out_stage.sv
module pdl_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic dis,
  input  logic tap_bit,
  output logic dout
);
  always_ff @(posedge clk) begin
    if (rst || dis) dout <= 1'b0;
    else            dout <= tap_bit;
  end

  assert_dis_clamps_R6: assert property (@(posedge clk) disable iff (rst)
    dis |=> !dout)
    else $error("output high while disabled");
endmodule

// File: rtl/prog_delay_line.sv
module prog_delay_line #(
  parameter int INHERENT = 2,
  parameter int STEP     = 1,
  parameter int ADDR_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dis,
  output logic              dout
);
  localparam int DEPTH   = pdl_pkg::chain_depth(INHERENT, STEP, ADDR_W);
  localparam int TOP_TAP = DEPTH - 1;

  logic [DEPTH-1:0] taps;
  logic             tap_bit;

  pdl_shift_chain #(.DEPTH(DEPTH)) u_chain (
    .clk  (clk),
    .rst  (rst),
    .din  (din),
    .taps (taps)
  );

  pdl_tap_select #(
    .INHERENT (INHERENT),
    .STEP     (STEP),
    .ADDR_W   (ADDR_W),
    .DEPTH    (DEPTH)
  ) u_sel (
    .clk     (clk),
    .rst     (rst),
    .taps    (taps),
    .addr    (addr),
    .tap_bit (tap_bit)
  );

  pdl_out_stage u_out (
    .clk     (clk),
    .rst     (rst),
    .dis     (dis),
    .tap_bit (tap_bit),
    .dout    (dout)
  );

  assert_rst_out_low_R8: assert property (@(posedge clk) rst |=> !dout)
    else $error("output high after reset");

  // Code 0 reads the shortest stage
  assert_min_delay_R2: assert property (@(posedge clk) disable iff (rst)
    (!dis && addr == '0) |=> (dout == $past(taps[INHERENT-1])))
    else $error("code 0 delay wrong");

  // Top code reads the last stage
  assert_max_delay_R3: assert property (@(posedge clk) disable iff (rst)
    (!dis && addr == '1) |=> (dout == $past(taps[TOP_TAP])))
    else $error("top code delay wrong");
endmodule

// File: tb/tb_prog_delay_line.sv
`timescale 1ns/1ps
module tb_prog_delay_line;
  localparam int INH   = 2;
  localparam int STP   = 1;
  localparam int AW    = 6;
  localparam int DEPTH = INH + 63 * STP;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          din = 1'b0;
  logic          dis = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          dout;

  int tests = 0;
  int fails = 0;
  bit hist [DEPTH];

  always #2.5 clk = ~clk;

  prog_delay_line #(.INHERENT(INH), .STEP(STP), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .din(din), .addr(addr), .dis(dis), .dout(dout)
  );

  function automatic int dly(input int a);
    return INH + a * STP;
  endfunction

  task automatic check_bit(input logic got, input bit exp, input string tag);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s dout=%0b expected=%0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic check_int(input int got, input int exp, input string tag);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s measured=%0d expected=%0d", tag, got, exp);
    end
  endtask

  // One clock: drive at negedge, update history model at posedge, compare 1ns later
  task automatic cyc(input bit d, input int a, input bit ds, input bit r, input string tag);
    bit e;
    @(negedge clk);
    din = d; addr = AW'(a); dis = ds; rst = r;
    @(posedge clk);
    e = r ? 1'b0 : (ds ? 1'b0 : hist[dly(a) - 1]);
    if (r) begin
      foreach (hist[k]) hist[k] = 1'b0;
    end else begin
      for (int k = DEPTH - 1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = d;
    end
    #1;
    check_bit(dout, e, tag);
  endtask

  // Send a lone pulse and count edges until it shows up
  task automatic measure(input int a, input string tag, output int got);
    for (int i = 0; i <= DEPTH; i++) cyc(1'b0, a, 1'b0, 1'b0, tag);
    cyc(1'b1, a, 1'b0, 1'b0, tag);
    got = -1;
    for (int i = 1; i <= DEPTH + 2; i++) begin
      cyc(1'b0, a, 1'b0, 1'b0, tag);
      if (got < 0 && dout === 1'b1) got = i;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int m;
    int prev;
    int a;
    void'($urandom(32'd20240611));

    // R8: reset state
    for (int i = 0; i < 3; i++) cyc(1'b0, 0, 1'b0, 1'b1, "R8 reset");

    // R8: fill with ones, reset, then ones must never emerge
    for (int i = 0; i < DEPTH + 2; i++) cyc(1'b1, 63, 1'b0, 1'b0, "R1 fill");
    cyc(1'b1, 63, 1'b0, 1'b1, "R8 reset mid-stream");
    for (int i = 0; i < DEPTH + 2; i++) cyc(1'b0, 63, 1'b0, 1'b0, "R8 cleared");

    // R2 / R3: extremes
    measure(0, "R2 min", m);
    check_int(m, dly(0), "R2 min delay");
    measure(63, "R3 max", m);
    check_int(m, dly(63), "R3 max delay");

    // R4: every code, step between neighbours
    prev = -1;
    for (int c = 0; c < 64; c++) begin
      measure(c, "R4 sweep", m);
      check_int(m, dly(c), "R1 delay per code");
      if (c > 0) check_int(m - prev, STP, "R4 step");
      prev = m;
    end

    // R5: live address over random history
    for (int i = 0; i < DEPTH; i++) cyc(1'($urandom), 63, 1'b0, 1'b0, "R1 random fill");
    for (int i = 0; i < 600; i++) begin
      if (i % 7 == 0) a = (i % 14 == 0) ? 0 : 63;
      else            a = int'($urandom % 64);
      cyc(1'($urandom), a, 1'b0, 1'b0, "R5 live address");
    end

    // R6: disable clamps regardless of data/address
    for (int i = 0; i < 40; i++)
      cyc(1'b1, int'($urandom % 64), 1'b1, 1'b0, "R6 disabled");

    // R7: data entered while disabled emerges after release
    for (int i = 0; i < 30; i++) cyc(1'($urandom), 40, 1'b1, 1'b0, "R6 disabled load");
    for (int i = 0; i < 60; i++) cyc(1'b0, 40, 1'b0, 1'b0, "R7 resume");

    // Mixed random run
    a = 10;
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 4 == 0) a = int'($urandom % 64);
      cyc(1'($urandom), a, ($urandom % 8 == 0), ($urandom % 300 == 0), "R1 mixed");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule